// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the configuration for one port of up to 32 general-purpose pins and turns it into per-pin pad controls. Each pin has a main control word and a drive control word, both on a single-cycle word-addressed register bus. The main word holds the pin's pull mode, power gating, buffer type, direction, output source select, polarity, function mux code, input-pad disable and a per-pin output value. Reading it back also returns the live pad level. The drive word holds slew rate and drive strength.

Two port-wide registers serve all pins at once. The parallel input register shows the gated pad levels. The parallel output register gives a second source for each pin's output. A pin takes its output either from its own stored value bit or from its bit in the parallel output register, and the parallel register only accepts a bit for a pin that has selected it. The bus has no wait states: a write lands at the clock edge, and read data is combinational from the current address.

Word address map: main control words at 0x000 + pin, drive control words at 0x140 + pin (byte offset 0x500 from the main array), parallel input at 0x080, parallel output at 0x0A0. Any other address is unmapped.

Top module: `gpio_pinbank`

## Requirements
- R1: After reset, every main control word and drive control word holds 0 and the parallel output register reads 0. Every pad output and output enable is 0. The pad level bit (bit 24) of a main word reads the pad input, because the input path is enabled at reset.
- R2: A main-word write stores bits 1:0 (pull), 3:2 (power gating), 8 (1 = open-drain), 9 (1 = output), 10 (1 = take output from the parallel register), 11 (polarity), 14:12 (mux code) and 15 (input-pad disable), and bit 16 (output value). All other bits read 0 except bit 24, and writes to bit 24 are ignored.
- R3: A drive-word write stores bit 0 (slew, 1 = fast) and bits 5:4 (drive strength, 00 = 2 mA up to 11 = 12 mA). All other bits read 0.
- R4: While a pin's bit 10 is 0, its pad output source is its bit 16. While bit 10 is 1, the source is its bit in the parallel output register.
- R5: A write to the parallel output register updates only the bits of pins whose bit 10 is 1. The other bits keep their value. The register reads back its stored bits.
- R6: When a pin's mux code is nonzero and its bit 11 is 1, the pad output is the inverse of the selected source. With mux code 0, bit 11 has no effect.
- R7: With bit 9 at 0, the output enable is 0. In push-pull mode (bit 8 = 0) it follows bit 9. In open-drain mode it is 1 only when bit 9 is 1 and the pad output is 0.
- R8: The open-drain flag output for pin i is its bit 8. Pull output bits [2i+1:2i] carry bits 1:0. Mux output bits [3i+2:3i] carry bits 14:12.
- R9: Bit 24 of a main word and the pin's bit in the parallel input register equal the pad input level. They read 0 when bit 15 is 1 or power gating is 10 (pad off). Gating values 00, 01 and 11 keep the input live.
- R10: A read from an unmapped address, or from any address in the unused gap of the map, returns 0. Writes there, and writes to the parallel input register, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 9 | Word address |
| busWrEn | input | 1 | Write strobe, data taken at the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| padIn | input | 32 | Pad input levels |
| padOut | output | 32 | Per-pin output value |
| padOe | output | 32 | Per-pin output enable |
| padOpenDrain | output | 32 | Per-pin open-drain select |
| padPull | output | 64 | Two pull-mode bits per pin |
| padMux | output | 96 | Three mux-code bits per pin |

## Verification
Two functions can act in the same cycle: the parallel output register takes a full-word write, and the per-pin source selection decides, bit by bit, whether that write is kept or dropped. The bench provokes this by letting random main-word writes leave bit 10 set on an arbitrary subset of pins, and then issuing full-width parallel writes. A directed case also sets bit 10 on exactly two pins first. Each outcome is judged by reading back the parallel register and comparing every pad output against a model that applies the write only to the selected pins. The bench also changes pad inputs at random between reads, so that the bit 24 and parallel input gating is judged against whatever pad level is current.

// File: rtl/gpiob_pkg.sv
`timescale 1ns/1ps
package gpiob_pkg;
  localparam int IDX_W = 8;

  localparam int F_PULL_LO = 0;
  localparam int F_PWRG_LO = 2;
  localparam int F_BUFT    = 8;
  localparam int F_DIR     = 9;
  localparam int F_AOD     = 10;
  localparam int F_POL     = 11;
  localparam int F_MUX_LO  = 12;
  localparam int F_INDIS   = 15;
  localparam int F_AVAL    = 16;
  localparam int F_PADIN   = 24;

  localparam logic [31:0] A_WMASK  = 32'h0001_FF0F;
  localparam logic [31:0] B_WMASK  = 32'h0000_0031;
  localparam logic [1:0]  PWRG_OFF = 2'b10;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRLA, RD_CTRLB, RD_PARIN, RD_PAROUT
  } rdSelE;

  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             wrPar;
    rdSelE            rdSel;
    logic [IDX_W-1:0] pinIdx;
  } busStrobeT;
endpackage

// File: rtl/gpiob_busdec.sv
`timescale 1ns/1ps
module gpiob_busdec
  import gpiob_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 9,
  parameter int CTRLB_BASE  = 'h140,
  parameter int PARIN_ADDR  = 'h080,
  parameter int PAROUT_ADDR = 'h0A0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobeT         strb
);
  localparam logic [ADDR_W-1:0] B_BASE = ADDR_W'(CTRLB_BASE);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (int'(busAddr) < NUM_PINS) begin
      strb.rdSel  = RD_CTRLA;
      strb.pinIdx = IDX_W'(busAddr);
      strb.wrA    = busWrEn;
    end else if (int'(busAddr) >= CTRLB_BASE && int'(busAddr) < CTRLB_BASE + NUM_PINS) begin
      strb.rdSel  = RD_CTRLB;
      strb.pinIdx = IDX_W'(busAddr - B_BASE);
      strb.wrB    = busWrEn;
    end else if (int'(busAddr) == PARIN_ADDR) begin
      strb.rdSel  = RD_PARIN;
    end else if (int'(busAddr) == PAROUT_ADDR) begin
      strb.rdSel  = RD_PAROUT;
      strb.wrPar  = busWrEn;
    end
  end

  // R10
  map_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= NUM_PINS && int'(busAddr) < PARIN_ADDR)
      |-> !(strb.wrA || strb.wrB || strb.wrPar));
endmodule

// File: rtl/gpiob_datapath.sv
`timescale 1ns/1ps
module gpiob_datapath
  import gpiob_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobeT             strb,
  input  logic [31:0]           busWrData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [31:0]           busRdData,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padOpenDrain,
  output logic [2*NUM_PINS-1:0] padPull,
  output logic [3*NUM_PINS-1:0] padMux
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic [31:0]         ctrlAQ [NUM_PINS];
  logic [31:0]         ctrlBQ [NUM_PINS];
  logic [NUM_PINS-1:0] parOutQ;
  logic [NUM_PINS-1:0] aodVec, dirVec, inEnVec, liveIn;
  logic [PIN_W-1:0]    pinSel;

  assign pinSel = strb.pinIdx[PIN_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PINS; k++) begin
        ctrlAQ[k] <= '0;
        ctrlBQ[k] <= '0;
      end
      parOutQ <= '0;
    end else begin
      for (int k = 0; k < NUM_PINS; k++) begin
        if (strb.wrA && int'(strb.pinIdx) == k) ctrlAQ[k] <= busWrData & A_WMASK;
        if (strb.wrB && int'(strb.pinIdx) == k) ctrlBQ[k] <= busWrData & B_WMASK;
        if (strb.wrPar && aodVec[k])            parOutQ[k] <= busWrData[k];
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    logic srcVal, isFunc, outVal;
    assign aodVec[g]  = ctrlAQ[g][F_AOD];
    assign dirVec[g]  = ctrlAQ[g][F_DIR];
    assign srcVal     = aodVec[g] ? parOutQ[g] : ctrlAQ[g][F_AVAL];
    assign isFunc     = |ctrlAQ[g][F_MUX_LO +: 3];
    assign outVal     = srcVal ^ (isFunc & ctrlAQ[g][F_POL]);
    assign padOut[g]  = outVal;
    assign padOe[g]   = dirVec[g] & (~ctrlAQ[g][F_BUFT] | ~outVal);
    assign padOpenDrain[g]    = ctrlAQ[g][F_BUFT];
    assign padPull[2*g +: 2]  = ctrlAQ[g][F_PULL_LO +: 2];
    assign padMux[3*g +: 3]   = ctrlAQ[g][F_MUX_LO +: 3];
    assign inEnVec[g] = ~ctrlAQ[g][F_INDIS] & (ctrlAQ[g][F_PWRG_LO +: 2] != PWRG_OFF);
    assign liveIn[g]  = padIn[g] & inEnVec[g];
  end

  always_comb begin
    busRdData = '0;
    unique case (strb.rdSel)
      RD_CTRLA:  busRdData = ctrlAQ[pinSel] | (32'(liveIn[pinSel]) << F_PADIN);
      RD_CTRLB:  busRdData = ctrlBQ[pinSel];
      RD_PARIN:  busRdData = 32'(liveIn);
      RD_PAROUT: busRdData = 32'(parOutQ);
      default:   busRdData = '0;
    endcase
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrA || strb.wrB) |-> int'(strb.pinIdx) < NUM_PINS);

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_CTRLA) |-> ((busRdData & ~(A_WMASK | (32'h1 << F_PADIN))) == '0));

  // R5
  par_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPar |=> (((parOutQ ^ $past(parOutQ)) & ~$past(aodVec)) == '0));

  // R5
  par_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPar |=> $stable(parOutQ));

  // R7
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~dirVec) == '0);

  // R7
  od_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOpenDrain & padOut) == '0);

  // R9
  in_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_PARIN) |-> ((busRdData[NUM_PINS-1:0] & ~inEnVec) == '0));
endmodule

// File: rtl/gpio_pinbank.sv
`timescale 1ns/1ps
module gpio_pinbank
  import gpiob_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 9,
  parameter int CTRLB_BASE  = 'h140,
  parameter int PARIN_ADDR  = 'h080,
  parameter int PAROUT_ADDR = 'h0A0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padOpenDrain,
  output logic [2*NUM_PINS-1:0] padPull,
  output logic [3*NUM_PINS-1:0] padMux
);
  busStrobeT strb;

  gpiob_busdec #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .CTRLB_BASE(CTRLB_BASE),
    .PARIN_ADDR(PARIN_ADDR), .PAROUT_ADDR(PAROUT_ADDR)
  ) uDec (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  gpiob_datapath #(.NUM_PINS(NUM_PINS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData), .padIn(padIn),
    .busRdData(busRdData), .padOut(padOut), .padOe(padOe),
    .padOpenDrain(padOpenDrain), .padPull(padPull), .padMux(padMux)
  );
endmodule

// File: tb/gpio_pinbank_test.sv
`timescale 1ns/1ps
module gpio_pinbank_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [8:0]  busAddr = '0;
  logic        busWrEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, padOpenDrain;
  logic [63:0] padPull;
  logic [95:0] padMux;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mA [32];
  logic [31:0] mB [32];
  logic [31:0] mPar;

  always #5 clk = ~clk;

  gpio_pinbank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padOpenDrain(padOpenDrain),
    .padPull(padPull), .padMux(padMux)
  );

  function automatic logic inEn(int i);
    return !mA[i][15] && (mA[i][3:2] != 2'b10);
  endfunction

  function automatic logic [31:0] liveVec();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = padIn[i] & inEn(i);
    return v;
  endfunction

  function automatic logic expVal(int i);
    logic src;
    src = mA[i][10] ? mPar[i] : mA[i][16];
    return (mA[i][14:12] != 3'd0 && mA[i][11]) ? ~src : src;
  endfunction

  function automatic logic [31:0] expRead(logic [8:0] a);
    logic [31:0] lv;
    lv = liveVec();
    if (a < 9'd32) return mA[a[4:0]] | (32'(lv[a[4:0]]) << 24);
    if (a >= 9'h140 && a < 9'h160) return mB[a[4:0]];
    if (a == 9'h080) return lv;
    if (a == 9'h0A0) return mPar;
    return 32'h0;
  endfunction

  function automatic string regionTag(logic [8:0] a);
    if (a < 9'd32) return "R2";
    if (a >= 9'h140 && a < 9'h160) return "R3";
    if (a == 9'h080) return "R9";
    if (a == 9'h0A0) return "R5";
    return "R10";
  endfunction

  task automatic chk(string req, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelWrite(logic [8:0] a, logic [31:0] d);
    if (a < 9'd32) mA[a[4:0]] = d & 32'h0001_FF0F;
    else if (a >= 9'h140 && a < 9'h160) mB[a[4:0]] = d & 32'h31;
    else if (a == 9'h0A0)
      for (int i = 0; i < 32; i++) if (mA[i][10]) mPar[i] = d[i];
  endtask

  task automatic busWrite(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic readChk(logic [8:0] a, string req);
    @(negedge clk);
    busAddr = a; busWrEn = 0;
    #1;
    chk(req, $sformatf("read 0x%0h", a), 96'(busRdData), 96'(expRead(a)));
  endtask

  task automatic pinsChk(string tag);
    logic [31:0] eOut, eOe, eOd;
    logic [63:0] ePull;
    logic [95:0] eMux;
    for (int i = 0; i < 32; i++) begin
      eOut[i] = expVal(i);
      eOe[i]  = mA[i][9] && (!mA[i][8] || !eOut[i]);
      eOd[i]  = mA[i][8];
      ePull[2*i +: 2] = mA[i][1:0];
      eMux[3*i +: 3]  = mA[i][14:12];
    end
    #1;
    chk({tag, " R4 R6"}, "padOut", 96'(padOut), 96'(eOut));
    chk({tag, " R7"}, "padOe", 96'(padOe), 96'(eOe));
    chk({tag, " R8"}, "padOpenDrain", 96'(padOpenDrain), 96'(eOd));
    chk({tag, " R8"}, "padPull", 96'(padPull), 96'(ePull));
    chk({tag, " R8"}, "padMux", padMux, eMux);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] a;
    void'($urandom(32'd7781));
    for (int i = 0; i < 32; i++) begin mA[i] = '0; mB[i] = '0; end
    mPar = '0;
    padIn = 32'hA5A5_0F0F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1 reset state
    pinsChk("R1");
    readChk(9'h000, "R1");
    readChk(9'h007, "R1");
    readChk(9'h140, "R1");
    readChk(9'h0A0, "R1");
    readChk(9'h080, "R1");

    // R2 reserved bits and bit 24 ignored; input disabled kills bit 24 (R9)
    busWrite(9'h003, 32'hFFFF_FFFF);
    readChk(9'h003, "R2");
    readChk(9'h080, "R9");

    // R3 drive word
    busWrite(9'h15F, 32'hFFFF_FFFF);
    readChk(9'h15F, "R3");
    busWrite(9'h141, 32'h0000_0021);
    readChk(9'h141, "R3");

    // R4 source from bit 16
    busWrite(9'h005, 32'h0001_0200);
    pinsChk("R4");
    // R5 parallel write dropped for pins without bit 10; pins 3 and 5 differ
    busWrite(9'h0A0, 32'hFFFF_FFFF);
    readChk(9'h0A0, "R5");
    busWrite(9'h005, 32'h0000_0600);
    pinsChk("R4");
    busWrite(9'h0A0, 32'hFFFF_FFFF);
    readChk(9'h0A0, "R5");
    pinsChk("R5");
    busWrite(9'h0A0, 32'h0000_0000);
    readChk(9'h0A0, "R5");
    pinsChk("R5");

    // R6 polarity ignored for mux 0, applied otherwise
    busWrite(9'h007, 32'h0001_0A00);
    pinsChk("R6");
    busWrite(9'h007, 32'h0001_3A00);
    pinsChk("R6");

    // R7 open drain
    busWrite(9'h009, 32'h0001_0300);
    pinsChk("R7");
    busWrite(9'h009, 32'h0000_0300);
    pinsChk("R7");

    // R9 power gating
    padIn = 32'hFFFF_FFFF;
    busWrite(9'h002, 32'h0000_0008);
    readChk(9'h002, "R9");
    readChk(9'h080, "R9");
    busWrite(9'h002, 32'h0000_0004);
    readChk(9'h002, "R9");
    busWrite(9'h002, 32'h0000_000C);
    readChk(9'h080, "R9");

    // R10 unmapped and read-only addresses
    busWrite(9'h100, 32'hFFFF_FFFF);
    readChk(9'h100, "R10");
    busWrite(9'h080, 32'h0000_0000);
    readChk(9'h080, "R10");
    busWrite(9'h020, 32'hFFFF_FFFF);
    readChk(9'h020, "R10");
    pinsChk("R10");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = int'($urandom % 6);
      case (kind)
        0, 1: a = 9'($urandom % 32);
        2:    a = 9'h140 + 9'($urandom % 32);
        3:    a = 9'h0A0;
        4:    a = 9'h080;
        default: a = 9'h1F0 + 9'($urandom % 16);
      endcase
      busWrite(a, $urandom);
      if (($urandom % 4) == 0) padIn = $urandom;
      pinsChk("rand");
      readChk(a, regionTag(a));
      readChk(9'($urandom % 32), "R2 R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule